// File: doc/BRIEF.md
# DMA Request Pulse Generator

This block turns two buffer events of a serial channel into active-low request strobes for a DMA controller. One event is "transmit buffer has become empty" and the other is "receive buffer now holds a character". When the matching enable is set, the rising edge of an event level drives the matching request output low for a fixed number of system clocks, three by default. A request whose enable is clear stays high.

The receive path also looks at the receive interrupt mode and at a special-receive-condition flag. In the interrupt-on-first-character-only mode, a receive event that comes with a special condition produces no request strobe. The block gives a one-clock interrupt strobe instead. An event that arrives while a strobe is in progress is recorded once. It is served after the output has been back high for one clock. Clearing an enable aborts the strobe in progress and drops anything recorded for that channel.

Top module: `dma_ready_pulser`

## Requirements
- R1: While reset is asserted, and on the first clock after it, both request outputs are high and the special-condition interrupt is low.
- R2: With the transmit enable high, a rising edge of the transmit-empty level sampled at clock edge k drives the transmit request low after edges k, k+1 and k+2. The request is high again after edge k+3 (three clocks low).
- R3: With the receive enable high and no suppression, a rising edge of the receive-available level drives the receive request low for three clocks. The timing is the same as in R2.
- R4: While an enable is low, its request output is high. An event seen while the enable is low is not recorded, so setting the enable later produces no strobe.
- R5: When the receive interrupt mode is 2'b01 (first character only) and the special flag is high in the clock of a receive rising edge, no receive strobe starts. The interrupt output is high for exactly the next clock. With the other mode values (2'b00, 2'b10, 2'b11), the special flag has no effect and the interrupt stays low.
- R6: An event level that stays high produces one strobe only. A new strobe needs the level to go low and then high again.
- R7: A rising edge seen at edges k+1 to k+3 of a strobe started at edge k is recorded, with at most one kept. Its strobe starts at edge k+4, after exactly one high clock. A rising edge at a later edge starts its strobe at once.
- R8: Clearing an enable during a strobe drives the output high after the next clock edge. A recorded event of that channel is discarded.
- R9: The transmit and receive channels work independently, including when both events happen in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_rdy_en | input | 1 | Enables transmit request strobes |
| rx_rdy_en | input | 1 | Enables receive request strobes |
| rx_int_mode | input | 2 | Receive interrupt mode; 2'b01 = first character only |
| tx_buf_empty | input | 1 | Level: transmit buffer is empty |
| rx_char_avail | input | 1 | Level: receive buffer holds a character |
| rx_special | input | 1 | Special receive condition present with the character |
| tx_req_n | output | 1 | Active-low transmit DMA request strobe |
| rx_req_n | output | 1 | Active-low receive DMA request strobe |
| rx_special_irq | output | 1 | One-clock special-receive-condition interrupt strobe |

## Verification
The assertions check these properties on every cycle:
- A low run never exceeds the strobe length.
- A run that ends while the enable is held has exactly that length.
- A disabled output goes high.
- The outputs are high after reset.
- An interrupt strobe is always caused by a receive edge that came with a special condition in first-character mode.

Some behaviours appear only in the bench scenarios:
- The exact start clock of each strobe.
- The one-clock gap before a recorded event is served, swept over every arrival offset.
- Ignoring of held levels.
- Discarding of events on a disabled or aborted channel.
- The full sweep of interrupt modes against the special flag and the enable.

// File: rtl/drp_pkg.sv
package drp_pkg;

  typedef enum logic [1:0] {
    RXI_OFF     = 2'b00,
    RXI_FIRST   = 2'b01,
    RXI_ALL_PAR = 2'b10,
    RXI_ALL     = 2'b11
  } rx_int_mode_e;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int NUM_CH = 2;

endpackage

// File: rtl/drp_edge_det.sv
module drp_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;

endmodule

// File: rtl/drp_pulse_gen.sv
module drp_pulse_gen #(
  parameter int PULSE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic trig,
  output logic req_n
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] left_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      left_q <= '0;
      pend_q <= 1'b0;
      req_n  <= 1'b1;
    end else if (left_q != '0) begin
      if (trig) pend_q <= 1'b1;
      if (left_q == ONE) begin
        left_q <= '0;
        req_n  <= 1'b1;
      end else begin
        left_q <= left_q - ONE;
      end
    end else if (trig || pend_q) begin
      left_q <= LOAD;
      pend_q <= 1'b0;
      req_n  <= 1'b0;
    end
  end

  // Checker state: length of the current low run, saturating.
  logic [CW-1:0] lowrun_q;
  always_ff @(posedge clk) begin
    if (rst || req_n)       lowrun_q <= '0;
    else if (lowrun_q != LOAD) lowrun_q <= lowrun_q + ONE;
  end

  // R2 R3
  width_cap_chk: assert property (@(posedge clk) disable iff (rst)
    !req_n |-> (lowrun_q < LOAD));

  // R2 R3
  full_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_n) && $past(en)) |-> (lowrun_q == LOAD));

  // R4 R8
  dis_high_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> req_n);

  // R1
  rst_high_chk: assert property (@(posedge clk)
    rst |=> req_n);

endmodule

// File: rtl/dma_ready_pulser.sv
module dma_ready_pulser #(
  parameter int PULSE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_rdy_en,
  input  logic       rx_rdy_en,
  input  logic [1:0] rx_int_mode,
  input  logic       tx_buf_empty,
  input  logic       rx_char_avail,
  input  logic       rx_special,
  output logic       tx_req_n,
  output logic       rx_req_n,
  output logic       rx_special_irq
);
  import drp_pkg::*;

  logic [NUM_CH-1:0] level, rise, en, trig, req_n;
  logic              block;

  assign level[CH_TX] = tx_buf_empty;
  assign level[CH_RX] = rx_char_avail;
  assign en[CH_TX]    = tx_rdy_en;
  assign en[CH_RX]    = rx_rdy_en;

  assign block = (rx_int_mode == RXI_FIRST) && rx_special;

  assign trig[CH_TX] = rise[CH_TX];
  assign trig[CH_RX] = rise[CH_RX] & ~block;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    drp_edge_det u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (level[i]),
      .rise  (rise[i])
    );
    drp_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk   (clk),
      .rst   (rst),
      .en    (en[i]),
      .trig  (trig[i]),
      .req_n (req_n[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rx_special_irq <= 1'b0;
    else     rx_special_irq <= rise[CH_RX] & block;
  end

  assign tx_req_n = req_n[CH_TX];
  assign rx_req_n = req_n[CH_RX];

  // R5
  sri_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_special_irq |-> ($past(rx_int_mode) == RXI_FIRST && $past(rx_special)
                        && $past(rx_char_avail)));

  // R5
  sri_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_special_irq |=> !rx_special_irq);

endmodule

// File: tb/tb_dma_ready_pulser.sv
module tb_dma_ready_pulser;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_rdy_en = 1'b0, rx_rdy_en = 1'b0;
  logic [1:0] rx_int_mode = 2'b00;
  logic       tx_buf_empty = 1'b0, rx_char_avail = 1'b0, rx_special = 1'b0;
  logic       tx_req_n, rx_req_n, rx_special_irq;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  dma_ready_pulser #(.PULSE_CYCLES(3)) dut (
    .clk(clk), .rst(rst),
    .tx_rdy_en(tx_rdy_en), .rx_rdy_en(rx_rdy_en), .rx_int_mode(rx_int_mode),
    .tx_buf_empty(tx_buf_empty), .rx_char_avail(rx_char_avail),
    .rx_special(rx_special),
    .tx_req_n(tx_req_n), .rx_req_n(rx_req_n), .rx_special_irq(rx_special_irq)
  );

  task automatic expect1(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b want %b", tag, act, exp);
    end
  endtask

  // Drive event levels for one clock edge, then check outputs after it.
  task automatic cyc(input logic t_ev, input logic r_ev,
                     input logic ex_tx, input logic ex_rx, input logic ex_irq,
                     input string tag);
    tx_buf_empty  = t_ev;
    rx_char_avail = r_ev;
    @(posedge clk);
    @(negedge clk);
    expect1({tag, " tx_req_n"}, tx_req_n, ex_tx);
    expect1({tag, " rx_req_n"}, rx_req_n, ex_rx);
    expect1({tag, " irq"}, rx_special_irq, ex_irq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout want completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset holds outputs high even with enables and events active
    tx_rdy_en = 1'b1; rx_rdy_en = 1'b1;
    for (int k = 0; k < 4; k++) cyc(k[0], ~k[0], 1'b1, 1'b1, 1'b0, "R1 reset");
    rst = 1'b0;
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R1 after reset");
    idle(3);

    // R2 R7: transmit strobe with a second edge swept over offsets
    for (int d = 2; d <= 9; d++) begin
      for (int k = 1; k <= 16; k++) begin
        int s;
        logic ev, lo;
        s  = (1 + d <= 4) ? 5 : 1 + d;
        ev = (k == 1) || (k == 1 + d);
        lo = (k >= 1 && k <= 3) || (k >= s && k <= s + 2);
        cyc(ev, 1'b0, ~lo, 1'b1, 1'b0, "R2 R7 R9 tx sweep");
      end
      idle(2);
    end

    // R3 R7: receive strobe with the same sweep
    for (int d = 2; d <= 9; d++) begin
      for (int k = 1; k <= 16; k++) begin
        int s;
        logic ev, lo;
        s  = (1 + d <= 4) ? 5 : 1 + d;
        ev = (k == 1) || (k == 1 + d);
        lo = (k >= 1 && k <= 3) || (k >= s && k <= s + 2);
        cyc(1'b0, ev, 1'b1, ~lo, 1'b0, "R3 R7 rx sweep");
      end
      idle(2);
    end

    // R7: several edges during one strobe are kept as a single request
    for (int k = 1; k <= 12; k++) begin
      logic ev, lo;
      ev = (k == 1) || (k == 3) || (k == 5) ? 1'b1 : 1'b0;
      // edge at 3 recorded -> strobe 5..7; edge at 5 starts? no: 5 is a start tick,
      // trigger and record coincide in the idle branch, so only one strobe 5..7
      lo = (k <= 3) || (k >= 5 && k <= 7);
      cyc(ev, 1'b0, ~lo, 1'b1, 1'b0, "R7 multi edge");
    end
    idle(2);

    // R6: a held level gives one strobe only
    for (int k = 1; k <= 10; k++) cyc(1'b1, 1'b1, k > 3, k > 3, 1'b0, "R6 held level");
    idle(3);

    // R4: disabled channel stays high and does not record
    tx_rdy_en = 1'b0; rx_rdy_en = 1'b0;
    for (int k = 1; k <= 5; k++) cyc(k <= 2, k <= 2, 1'b1, 1'b1, 1'b0, "R4 disabled");
    tx_rdy_en = 1'b1; rx_rdy_en = 1'b1;
    for (int k = 1; k <= 6; k++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 enabled later");

    // R8: abort during strobe, pending discarded
    for (int k = 1; k <= 14; k++) begin
      logic lo;
      if (k == 4) tx_rdy_en = 1'b0;
      if (k == 7) tx_rdy_en = 1'b1;
      lo = (k <= 3);
      cyc((k == 1) || (k == 3), 1'b0, ~lo, 1'b1, 1'b0, "R8 abort");
    end
    idle(2);

    // R5: mode x special x enable sweep on the receive side
    for (int m = 0; m < 4; m++) begin
      for (int sp = 0; sp < 2; sp++) begin
        for (int e = 0; e < 2; e++) begin
          logic blk;
          blk = (m == 1) && (sp == 1);
          rx_int_mode = 2'(m);
          rx_rdy_en   = e[0];
          for (int k = 1; k <= 6; k++) begin
            logic lo;
            rx_special = (k == 1) ? sp[0] : 1'b0;
            lo = e[0] && !blk && (k <= 3);
            cyc(1'b0, k == 1, 1'b1, ~lo, blk && (k == 1), "R5 mode sweep");
          end
          idle(2);
        end
      end
    end
    rx_int_mode = 2'b00; rx_rdy_en = 1'b1; rx_special = 1'b0;

    // R9: both channels in the same clock, then offset
    for (int k = 1; k <= 10; k++) begin
      logic lt, lr;
      lt = (k <= 3);
      lr = (k <= 3) || (k >= 6 && k <= 8);
      cyc(k == 1, (k == 1) || (k == 6), ~lt, ~lr, 1'b0, "R9 both channels");
    end
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule